// File: doc/BRIEF.md
# Phrase Fetch Sequencer

This block plays compressed phrases out of a byte-wide external ROM for up to four voice channels. Software, or a command decoder in front of it, starts a channel by naming a 9-bit phrase number. The channel then reads that phrase's 8-byte header record, which sits in the table at the bottom of the ROM. From the record it takes a 24-bit first-byte pointer and a 24-bit last-byte pointer. It then walks the data bytes between them, and on every sample tick it hands one 4-bit code to the downstream decoder. The decoding of those codes is not part of this block.

All channels share a single ROM port. The port keeps one read in flight at a time. Its address stays on the bus for a fixed, configurable number of clocks before the data byte is taken. When the port is free, a round-robin arbiter picks which channel reads next. A channel can be halted at any time. A halted channel goes quiet at the next sample tick and drops back to idle.

Top module: `phrase_fetch_seq`

## Requirements
- R1: The header record of phrase p is read at addresses p*8+0 to p*8+5. Bits 11:3 of the address carry the phrase number, bits 2:0 carry the byte index, and every bit above 11 is zero.
- R2: Header bytes 0, 1 and 2 give the 24-bit first-byte pointer, most significant byte first. Header bytes 3, 4 and 5 give the 24-bit last-byte pointer in the same order.
- R3: Data bytes are read at ascending addresses from the first pointer to the last pointer. Each byte yields its bits 7:4 first and its bits 3:0 second. Each code is delivered on `nib_o` with a one-cycle `nib_valid_o` pulse, in the cycle after the tick that released it.
- R4: The code taken from bits 3:0 of the byte at the last pointer is the final code of the phrase. `eop_o` pulses for one cycle together with it, and `busy_o` for that channel is low in that same cycle.
- R5: A ROM address stays unchanged on `rom_addr_o` while its read is outstanding. The data byte is taken after RD_LAT clock edges have passed since the address appeared.
- R6: A tick that finds no data byte ready for a channel produces no code for that channel, and no code is lost. The next tick after the byte arrives delivers the code that was pending.
- R7: A halt request for a busy channel takes effect at the next tick. At that tick the channel emits no code and no end pulse, and it returns to idle. `busy_o` falls as soon as any outstanding read has completed. Halting one channel does not disturb the others.
- R8: A start request is accepted only when the addressed channel is idle and the phrase number is nonzero. Any other start request is ignored.
- R9: When the ROM port is free, it is granted to the first requesting channel after the one served last, in ascending order with wrap-around.
- R10: After reset every channel is idle, `busy_o`, `nib_valid_o` and `eop_o` are all zero, and `rom_addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | Start request for channel `cmd_ch_i` |
| cmd_ch_i | input | CH_W | Channel addressed by the start request |
| cmd_phrase_i | input | 9 | Phrase number for the start request |
| halt_i | input | NUM_CH | Per-channel halt request, several may be set at once |
| tick_i | input | 1 | Sample tick, shared by all channels |
| rom_addr_o | output | 24 | External ROM address |
| rom_data_i | input | 8 | External ROM data |
| busy_o | output | NUM_CH | Channel is playing or still owns a read in flight |
| nib_valid_o | output | NUM_CH | One-cycle strobe: a new code is on `nib_o` |
| nib_o | output | 4*NUM_CH | Code per channel, channel i in bits 4i+3:4i |
| eop_o | output | NUM_CH | One-cycle end-of-phrase strobe |

## Verification
A code and any end pulse are due exactly one clock after the cycle in which `tick_i` is high. The bench drives the tick for one cycle and reads the outputs on the following falling edge, with no extra waiting. A ROM read takes RD_LAT+2 cycles from grant until the port is free again. A full header walk therefore takes roughly six times that, and the bench allows generous fixed gaps before ticking so that data is always ready, except in the deliberate underrun case. The bench's ROM model returns the byte for an address only after that address has sat on the bus for RD_LAT edges, so any error in the read latency shows up as wrong codes. The grant order is checked through the sequence of addresses seen on the ROM bus while four headers are being walked at once.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    // external ROM geometry
    localparam int ROM_AW   = 24;
    localparam int ROM_DW   = 8;
    localparam int PHR_W    = 9;
    localparam int NIB_W    = 4;
    // header record: byte index field and last byte used
    localparam int HIDX_W   = 3;
    localparam int HDR_LAST = 5;
    // zero bits above the phrase field in a header address
    localparam int HDR_PAD  = ROM_AW - PHR_W - HIDX_W;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_HDR  = 2'd1,
        CH_PLAY = 2'd2
    } ch_state_e;

    typedef struct packed {
        ch_state_e           st;
        logic [PHR_W-1:0]    phrase;
        logic [HIDX_W-1:0]   hidx;
        logic [ROM_AW-1:0]   first_a;
        logic [ROM_AW-1:0]   last_a;
        logic [ROM_AW-1:0]   cur;
        logic [ROM_DW-1:0]   byt;
        logic                have;
        logic                lo;
        logic                infl;
        logic                halt;
        logic                nv;
        logic [NIB_W-1:0]    nib;
        logic                eop;
    } ch_regs_t;

endpackage

// File: rtl/pfs_arbiter.sv
module pfs_arbiter #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          free_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] gidx_o
);

    logic [IW-1:0] last_d, last_q;
    logic          found;

    always_comb begin
        grant_o = '0;
        gidx_o  = '0;
        found   = 1'b0;
        for (int i = 1; i <= N; i++) begin
            int idx;
            idx = (int'(last_q) + i) % N;
            if (!found && free_i && req_i[idx]) begin
                found        = 1'b1;
                grant_o[idx] = 1'b1;
                gidx_o       = IW'(idx);
            end
        end
        last_d = found ? gidx_o : last_q;
    end

    // start so that channel 0 wins first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= IW'(N - 1);
        else        last_q <= last_d;
    end

endmodule

// File: rtl/pfs_rom_port.sv
module pfs_rom_port #(
    parameter int AW     = 24,
    parameter int RD_LAT = 3,
    parameter int IW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [IW-1:0] owner_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] rom_addr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [IW-1:0] owner_o
);

    localparam int CNT_W = $clog2(RD_LAT + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic [IW-1:0]    owner;
    } port_regs_t;

    port_regs_t d, q;

    always_comb begin
        d      = q;
        done_o = q.busy && (q.cnt == CNT_W'(RD_LAT));
        if (!q.busy) begin
            if (load_i) begin
                d.busy  = 1'b1;
                d.cnt   = '0;
                d.addr  = addr_i;
                d.owner = owner_i;
            end
        end else if (done_o) begin
            d.busy = 1'b0;
        end else begin
            d.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rom_addr_o = q.addr;
    assign busy_o     = q.busy;
    assign owner_o    = q.owner;

endmodule

// File: rtl/pfs_channel.sv
module pfs_channel
    import pfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PHR_W-1:0]  phrase_i,
    input  logic              halt_i,
    input  logic              tick_i,
    input  logic              grant_i,
    input  logic              rd_done_i,
    input  logic [ROM_DW-1:0] rd_data_i,
    output logic              req_o,
    output logic [ROM_AW-1:0] addr_o,
    output logic              busy_o,
    output logic              nib_valid_o,
    output logic [NIB_W-1:0]  nib_o,
    output logic              eop_o
);

    ch_regs_t d, q;

    always_comb begin
        d     = q;
        d.nv  = 1'b0;
        d.eop = 1'b0;

        if (grant_i) d.infl = 1'b1;

        // returning read: header byte or sample byte
        if (rd_done_i) begin
            d.infl = 1'b0;
            if (q.st == CH_HDR) begin
                case (q.hidx)
                    3'd0:    d.first_a[23:16] = rd_data_i;
                    3'd1:    d.first_a[15:8]  = rd_data_i;
                    3'd2:    d.first_a[7:0]   = rd_data_i;
                    3'd3:    d.last_a[23:16]  = rd_data_i;
                    3'd4:    d.last_a[15:8]   = rd_data_i;
                    default: d.last_a[7:0]    = rd_data_i;
                endcase
                if (q.hidx == HIDX_W'(HDR_LAST)) begin
                    d.st   = CH_PLAY;
                    d.cur  = q.first_a;
                    d.hidx = '0;
                    d.have = 1'b0;
                    d.lo   = 1'b0;
                end else begin
                    d.hidx = q.hidx + HIDX_W'(1);
                end
            end else if (q.st == CH_PLAY) begin
                d.byt  = rd_data_i;
                d.have = 1'b1;
            end
        end

        if (halt_i && q.st != CH_IDLE) d.halt = 1'b1;

        // sample tick
        if (tick_i && q.st != CH_IDLE) begin
            if (q.halt) begin
                d.st   = CH_IDLE;
                d.halt = 1'b0;
                d.have = 1'b0;
            end else if (q.st == CH_PLAY && q.have) begin
                d.nv  = 1'b1;
                d.nib = q.lo ? q.byt[3:0] : q.byt[7:4];
                if (!q.lo) begin
                    d.lo = 1'b1;
                end else begin
                    d.lo   = 1'b0;
                    d.have = 1'b0;
                    if (q.cur == q.last_a) begin
                        d.st  = CH_IDLE;
                        d.eop = 1'b1;
                    end else begin
                        d.cur = q.cur + ROM_AW'(1);
                    end
                end
            end
        end

        // start: only from idle with nothing in flight and a valid phrase
        if (start_i && q.st == CH_IDLE && !q.infl && phrase_i != '0) begin
            d.st     = CH_HDR;
            d.phrase = phrase_i;
            d.hidx   = '0;
            d.halt   = 1'b0;
            d.have   = 1'b0;
            d.lo     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_o  = !q.infl && ((q.st == CH_HDR) || (q.st == CH_PLAY && !q.have));
    assign addr_o = (q.st == CH_HDR) ? {{HDR_PAD{1'b0}}, q.phrase, q.hidx} : q.cur;
    assign busy_o = (q.st != CH_IDLE) || q.infl;
    assign nib_valid_o = q.nv;
    assign nib_o       = q.nib;
    assign eop_o       = q.eop;

endmodule

// File: rtl/phrase_fetch_seq.sv
module phrase_fetch_seq
    import pfs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RD_LAT = 3,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_start_i,
    input  logic [CH_W-1:0]         cmd_ch_i,
    input  logic [PHR_W-1:0]        cmd_phrase_i,
    input  logic [NUM_CH-1:0]       halt_i,
    input  logic                    tick_i,
    output logic [ROM_AW-1:0]       rom_addr_o,
    input  logic [ROM_DW-1:0]       rom_data_i,
    output logic [NUM_CH-1:0]       busy_o,
    output logic [NUM_CH-1:0]       nib_valid_o,
    output logic [NUM_CH*NIB_W-1:0] nib_o,
    output logic [NUM_CH-1:0]       eop_o
);

    logic [NUM_CH-1:0] req;
    logic [NUM_CH-1:0] grant;
    logic [CH_W-1:0]   gidx;
    logic [CH_W-1:0]   owner;
    logic              port_busy;
    logic              rd_done;
    logic [ROM_AW-1:0] ch_addr [NUM_CH];
    logic [ROM_AW-1:0] addr_sel;

    pfs_arbiter #(.N(NUM_CH), .IW(CH_W)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .free_i  (!port_busy),
        .grant_o (grant),
        .gidx_o  (gidx)
    );

    assign addr_sel = ch_addr[gidx];

    pfs_rom_port #(.AW(ROM_AW), .RD_LAT(RD_LAT), .IW(CH_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (|grant),
        .owner_i    (gidx),
        .addr_i     (addr_sel),
        .rom_addr_o (rom_addr_o),
        .busy_o     (port_busy),
        .done_o     (rd_done),
        .owner_o    (owner)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pfs_channel u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .start_i     (cmd_start_i && (cmd_ch_i == CH_W'(i))),
            .phrase_i    (cmd_phrase_i),
            .halt_i      (halt_i[i]),
            .tick_i      (tick_i),
            .grant_i     (grant[i]),
            .rd_done_i   (rd_done && (owner == CH_W'(i))),
            .rd_data_i   (rom_data_i),
            .req_o       (req[i]),
            .addr_o      (ch_addr[i]),
            .busy_o      (busy_o[i]),
            .nib_valid_o (nib_valid_o[i]),
            .nib_o       (nib_o[i*NIB_W +: NIB_W]),
            .eop_o       (eop_o[i])
        );
    end

endmodule

module pfs_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] req,
    input logic [NUM_CH-1:0] grant,
    input logic              port_busy,
    input logic              rd_done,
    input logic [23:0]       rom_addr_o,
    input logic [NUM_CH-1:0] busy_o,
    input logic [NUM_CH-1:0] nib_valid_o,
    input logic [NUM_CH-1:0] eop_o
);

    // R4
    eop_with_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_o & ~nib_valid_o) == '0);

    // R4
    eop_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|eop_o) |=> ((eop_o & $past(eop_o)) == '0));

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $stable(rom_addr_o));

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));

    // R9
    grant_idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_busy |-> (grant == '0));

    // R3
    nib_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|nib_valid_o) |-> ((nib_valid_o & ~$past(busy_o)) == '0));

endmodule

bind phrase_fetch_seq pfs_chk #(.NUM_CH(NUM_CH)) u_pfs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .grant       (grant),
    .port_busy   (port_busy),
    .rd_done     (rd_done),
    .rom_addr_o  (rom_addr_o),
    .busy_o      (busy_o),
    .nib_valid_o (nib_valid_o),
    .eop_o       (eop_o)
);

// File: tb/sim_phrase_fetch_seq.sv
module sim_phrase_fetch_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int LAT        = 3;
    localparam int WD_CYC     = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_start_i = 1'b0;
    logic [1:0]        cmd_ch_i = '0;
    logic [8:0]        cmd_phrase_i = '0;
    logic [NCH-1:0]    halt_i = '0;
    logic              tick_i = 1'b0;
    logic [23:0]       rom_addr_o;
    logic [7:0]        rom_data_i;
    logic [NCH-1:0]    busy_o, nib_valid_o, eop_o;
    logic [NCH*4-1:0]  nib_o;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phrase_fetch_seq #(.NUM_CH(NCH), .RD_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start_i), .cmd_ch_i(cmd_ch_i),
        .cmd_phrase_i(cmd_phrase_i), .halt_i(halt_i), .tick_i(tick_i),
        .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i), .busy_o(busy_o),
        .nib_valid_o(nib_valid_o), .nib_o(nib_o), .eop_o(eop_o)
    );

    // ---------------- ROM model with LAT-edge read delay ----------------
    function automatic logic [23:0] first_of(input int p);
        return 24'(((p % 200) + 1) * 65536 + p);
    endfunction

    function automatic int nbytes(input int p);
        return (p % 5) + 1;
    endfunction

    function automatic logic [7:0] rom_byte(input logic [23:0] a);
        logic [23:0] s, e;
        logic [7:0]  v;
        int p;
        if (a < 24'h1000) begin
            p = int'(a[11:3]);
            s = first_of(p);
            e = s + 24'(nbytes(p) - 1);
            case (a[2:0])
                3'd0: return s[23:16];
                3'd1: return s[15:8];
                3'd2: return s[7:0];
                3'd3: return e[23:16];
                3'd4: return e[15:8];
                3'd5: return e[7:0];
                default: return 8'hEE;
            endcase
        end
        v = a[7:0] * 8'd29;
        v = v ^ a[15:8];
        v = v + a[23:16] + 8'd5;
        return v;
    endfunction

    function automatic logic [3:0] exp_nib(input int p, input int k);
        logic [7:0] b;
        b = rom_byte(first_of(p) + 24'(k / 2));
        return (k % 2 == 0) ? b[7:4] : b[3:0];
    endfunction

    logic [23:0] apipe [LAT];
    always_ff @(posedge clk) begin
        apipe[0] <= rom_addr_o;
        for (int i = 1; i < LAT; i++) apipe[i] <= apipe[i-1];
    end
    always_comb rom_data_i = rom_byte(apipe[LAT-1]);

    // ---------------- address recorder for the grant-order test ----------------
    logic        rec_en = 1'b0;
    int          rec_n = 0;
    logic [23:0] rec [24];
    logic [23:0] prev_a = '0;
    always @(negedge clk) begin
        if (rec_en && rom_addr_o != prev_a && rec_n < 24) begin
            rec[rec_n] = rom_addr_o;
            rec_n = rec_n + 1;
        end
        prev_a = rom_addr_o;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input int ch, input int p);
        cmd_start_i  = 1'b1;
        cmd_ch_i     = 2'(ch);
        cmd_phrase_i = 9'(p);
        @(negedge clk);
        cmd_start_i  = 1'b0;
    endtask

    // tick high for one cycle; outputs read on the next falling edge
    task automatic pulse_tick();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic play_range(input int ch, input int p, input int k0, input int k1);
        int tot;
        tot = 2 * nbytes(p);
        for (int k = k0; k < k1; k++) begin
            pulse_tick();
            chk("R3 valid strobe", 32'(nib_valid_o[ch]), 32'd1);
            chk("R2 R3 R5 code value", 32'(nib_o[ch*4 +: 4]), 32'(exp_nib(p, k)));
            chk("R4 end pulse", 32'(eop_o[ch]), 32'(k == tot - 1));
            if (k == tot - 1) chk("R4 busy low at end", 32'(busy_o[ch]), 32'd0);
            cyc(12);
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R10 reset state
        chk("R10 busy", 32'(busy_o), 32'd0);
        chk("R10 valid", 32'(nib_valid_o), 32'd0);
        chk("R10 eop", 32'(eop_o), 32'd0);
        chk("R10 rom address", 32'(rom_addr_o), 32'd0);

        // R8 phrase zero ignored
        do_start(1, 0);
        cyc(3);
        chk("R8 phrase zero", 32'(busy_o), 32'd0);

        // sweep of single-channel playback across the phrase range
        begin
            int plist [14] = '{1, 2, 3, 4, 5, 8, 64, 100, 255, 256, 300, 509, 510, 511};
            for (int i = 0; i < 14; i++) begin
                do_start(i % NCH, plist[i]);
                cyc(60);
                play_range(i % NCH, plist[i], 0, 2 * nbytes(plist[i]));
            end
        end

        // R8 start while busy is ignored: phrase 3 must play, not 7
        do_start(0, 3);
        cyc(5);
        do_start(0, 7);
        cyc(60);
        play_range(0, 3, 0, 2 * nbytes(3));

        // R6 tick before any data: nothing, nothing lost
        do_start(2, 6);
        cyc(2);
        pulse_tick();
        chk("R6 no code during header walk", 32'(nib_valid_o), 32'd0);
        cyc(60);
        play_range(2, 6, 0, 2 * nbytes(6));

        // R7 halt mid-phrase
        do_start(1, 4);
        cyc(60);
        play_range(1, 4, 0, 3);
        halt_i = 4'b0010;
        @(negedge clk);
        halt_i = '0;
        cyc(2);
        pulse_tick();
        chk("R7 no code at halt tick", 32'(nib_valid_o[1]), 32'd0);
        chk("R7 no end pulse at halt", 32'(eop_o[1]), 32'd0);
        cyc(10);
        chk("R7 idle after halt", 32'(busy_o[1]), 32'd0);
        // R7 halt of other channels leaves channel 0 playing
        do_start(0, 9);
        cyc(60);
        play_range(0, 9, 0, 2);
        halt_i = 4'b1100;
        @(negedge clk);
        halt_i = '0;
        play_range(0, 9, 2, 2 * nbytes(9));
        // channel 1 restarts cleanly after halt
        do_start(1, 2);
        cyc(60);
        play_range(1, 2, 0, 2 * nbytes(2));

        // R9 round-robin grant order over four concurrent header walks
        begin
            int ph [4] = '{17, 18, 19, 20};
            int tot;
            rec_en = 1'b1;
            for (int c = 0; c < NCH; c++) do_start(c, ph[c]);
            cyc(200);
            rec_en = 1'b0;
            chk("R9 recorded reads", 32'(rec_n), 32'd24);
            for (int r = 0; r < 6; r++)
                for (int c = 0; c < NCH; c++)
                    chk("R1 R9 header address order", 32'(rec[r*4 + c]), 32'(ph[c]*8 + r));
            // concurrent playback on all four channels
            for (int k = 0; k < 10; k++) begin
                pulse_tick();
                for (int c = 0; c < NCH; c++) begin
                    tot = 2 * nbytes(ph[c]);
                    if (k < tot) begin
                        chk("R3 concurrent valid", 32'(nib_valid_o[c]), 32'd1);
                        chk("R3 R5 concurrent code", 32'(nib_o[c*4 +: 4]), 32'(exp_nib(ph[c], k)));
                        chk("R4 concurrent end", 32'(eop_o[c]), 32'(k == tot - 1));
                    end else begin
                        chk("R4 quiet after end", 32'(nib_valid_o[c]), 32'd0);
                    end
                end
                cyc(30);
            end
            chk("R4 all idle", 32'(busy_o), 32'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule